// File: doc/BRIEF.md
# APB Transfer Requester

This block sits on the bridge side of a peripheral bus and turns single read or write commands into APB transfers. A command (address, direction, write data) is offered on a valid/ready handshake. The block decodes the target peripheral from a four-bit field of the address and raises that peripheral's select line. It then moves through a one-cycle setup phase and an access phase. The access phase lasts as long as the selected peripheral holds PREADY low.

When the access phase ends, the block captures the read data and the error indication. It reports them on a registered one-cycle completion pulse. A command that is waiting when a transfer ends is taken at once, and its setup phase follows directly with no idle cycle between. An address that maps to no peripheral never reaches the bus. It is answered with an error completion on the next cycle.

Top module: `apbm_requester`

## Requirements
- R1: While rst_n is low and right after it is released, psel is all zeros, penable is 0, rsp_done is 0 and cmd_ready is 1.
- R2: Address bits [15:12] pick the peripheral. A field value i below NUM_SLV (4) drives only psel[i] high. Values 4 to 15 are unmapped. At most one select bit is ever high.
- R3: An accepted mapped command gives exactly one setup cycle, with the select high and penable low, in the cycle after acceptance. The cycle after that is an access cycle with penable high.
- R4: During access cycles with pready low, the block holds penable high and keeps paddr, pwrite, pwdata and psel unchanged.
- R5: The block stays in access while pready is low. With W wait cycles, rsp_done rises W+3 cycles after the accepting clock edge.
- R6: rsp_done is high for exactly the one cycle after the access cycle in which pready is high. rsp_err then equals pslverr. rsp_rdata equals prdata for a read and zero for a write.
- R7: A mapped command accepted in the completing access cycle is followed directly by its setup cycle. psel stays high, with the new peripheral's bit, and penable is low in that cycle.
- R8: After a completion with no command pending, psel returns to all zeros and penable to 0.
- R9: An unmapped command is accepted only when the bus is idle. It raises no select. It gives rsp_done one cycle after acceptance, with rsp_err 1 and rsp_rdata 0.
- R10: cmd_ready is high when idle, and in a completing access cycle only if the offered address is mapped. It is low in setup cycles and in access cycles with pready low.
- R11: pwrite carries the command direction (1 for write, 0 for read). pwdata carries the command's write data to the peripheral.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken at this edge when valid |
| cmd_addr | input | AW | Command address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data of the completed transfer |
| rsp_err | output | 1 | Error flag of the completed transfer |
| psel | output | NUM_SLV | One select line per peripheral |
| penable | output | 1 | High in access cycles |
| paddr | output | AW | Bus address |
| pwrite | output | 1 | Bus direction |
| pwdata | output | DW | Bus write data |
| pready | input | 1 | Peripheral ready / access extension |
| prdata | input | DW | Peripheral read data |
| pslverr | input | 1 | Peripheral error |

## Verification
Two events can land in the same cycle: the finish of one transfer and the acceptance of the next. They coincide when cmd_valid is held through an access cycle whose pready is high. The bench provokes this with a second command to a different peripheral, and with an unmapped command that must be refused in that cycle. It then judges the next cycle. For the mapped case, the completion pulse and data of the first transfer must appear while psel already shows the second peripheral with penable low. For the unmapped case, the error completion must come only after the bus has gone idle.

// File: rtl/apbm_pkg.sv
package apbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } apbm_state_e;
endpackage

// File: rtl/apbm_decode.sv
// Peripheral select decode from the address select field.
module apbm_decode #(
  parameter int NUM_SLV = 4,
  parameter int SEL_W   = 4
) (
  input  logic [SEL_W-1:0]   fld,
  output logic [NUM_SLV-1:0] sel,
  output logic               hit
);
  generate
    for (genvar i = 0; i < NUM_SLV; i++) begin : g_sel
      assign sel[i] = (fld == SEL_W'(i));
    end
  endgenerate

  assign hit = |sel;
endmodule

// File: rtl/apbm_fsm.sv
// Phase sequencer: idle, one setup cycle, access stretched by pready.
module apbm_fsm
  import apbm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        pready,
  output apbm_state_e state
);
  apbm_state_e state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (start) state_nx = ST_SETUP;
      ST_SETUP:  state_nx = ST_ACCESS;
      ST_ACCESS: if (pready) state_nx = start ? ST_SETUP : ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/apbm_resp.sv
// Registered completion: pulse, read data and error flag.
module apbm_resp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          complete,
  input  logic          miss,
  input  logic          is_write,
  input  logic [DW-1:0] prdata,
  input  logic          pslverr,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          err
);
  logic          load_en;
  logic [DW-1:0] rdata_nx;
  logic          err_nx;

  assign load_en = complete | miss;

  always_comb begin
    if (complete) begin
      rdata_nx = is_write ? '0 : prdata;
      err_nx   = pslverr;
    end else begin
      rdata_nx = '0;
      err_nx   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      done <= load_en;
      if (load_en) begin
        rdata <= rdata_nx;
        err   <= err_nx;
      end
    end
  end
endmodule

// File: rtl/apbm_requester.sv
// APB transfer requester: command handshake in, APB phases out.
module apbm_requester
  import apbm_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int NUM_SLV = 4,
  parameter int SEL_LSB = 12,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [AW-1:0]      cmd_addr,
  input  logic               cmd_write,
  input  logic [DW-1:0]      cmd_wdata,
  output logic               rsp_done,
  output logic [DW-1:0]      rsp_rdata,
  output logic               rsp_err,
  output logic [NUM_SLV-1:0] psel,
  output logic               penable,
  output logic [AW-1:0]      paddr,
  output logic               pwrite,
  output logic [DW-1:0]      pwdata,
  input  logic               pready,
  input  logic [DW-1:0]      prdata,
  input  logic               pslverr
);
  apbm_state_e        state;
  logic [NUM_SLV-1:0] dec_sel;
  logic               dec_hit;
  logic [NUM_SLV-1:0] sel_q;
  logic               completing;
  logic               accept;
  logic               start;
  logic               miss;

  apbm_decode #(.NUM_SLV(NUM_SLV), .SEL_W(SEL_W)) u_decode (
    .fld (cmd_addr[SEL_LSB +: SEL_W]),
    .sel (dec_sel),
    .hit (dec_hit)
  );

  assign completing = (state == ST_ACCESS) & pready;
  assign cmd_ready  = (state == ST_IDLE) | (completing & dec_hit);
  assign accept     = cmd_valid & cmd_ready;
  assign start      = accept & dec_hit;
  assign miss       = accept & ~dec_hit;

  apbm_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .pready (pready),
    .state  (state)
  );

  // Command register, loaded only when a mapped command is taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr  <= '0;
      pwrite <= 1'b0;
      pwdata <= '0;
      sel_q  <= '0;
    end else if (start) begin
      paddr  <= cmd_addr;
      pwrite <= cmd_write;
      pwdata <= cmd_wdata;
      sel_q  <= dec_sel;
    end
  end

  assign psel    = (state != ST_IDLE) ? sel_q : '0;
  assign penable = (state == ST_ACCESS);

  apbm_resp #(.DW(DW)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .complete (completing),
    .miss     (miss),
    .is_write (pwrite),
    .prdata   (prdata),
    .pslverr  (pslverr),
    .done     (rsp_done),
    .rdata    (rsp_rdata),
    .err      (rsp_err)
  );
endmodule

// File: rtl/apbm_requester_chk.sv
module apbm_requester_chk #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int NUM_SLV = 4,
  parameter int SEL_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [SEL_W-1:0]   sel_field,
  input logic [NUM_SLV-1:0] psel,
  input logic               penable,
  input logic [AW-1:0]      paddr,
  input logic               pwrite,
  input logic [DW-1:0]      pwdata,
  input logic               pready,
  input logic               rsp_done,
  input logic               rsp_err,
  input logic [DW-1:0]      rsp_rdata
);
  logic unmapped;
  assign unmapped = int'(sel_field) >= NUM_SLV;

  // R2
  a_r2_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(psel));

  // R3
  a_r3_setup_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (psel != '0 && !penable) |=> (penable && psel != '0));

  // R4
  a_r4_access_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && !pready) |=> (penable && $stable(paddr) && $stable(pwrite)
                              && $stable(pwdata) && $stable(psel)));

  // R6
  a_r6_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && pready) |=> rsp_done);

  // R7
  a_r7_direct_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && pready && cmd_valid && cmd_ready) |=> (psel != '0 && !penable));

  // R8
  a_r8_enable_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> (psel != '0));

  // R9
  a_r9_unmapped_error: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && unmapped) |=> (rsp_done && rsp_err
                                              && rsp_rdata == '0 && psel == '0));

  // R10
  a_r10_no_ready_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (psel != '0 && !penable) |-> !cmd_ready);
endmodule

bind apbm_requester apbm_requester_chk #(
  .AW(AW), .DW(DW), .NUM_SLV(NUM_SLV), .SEL_W(SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .sel_field (cmd_addr[SEL_LSB +: SEL_W]),
  .psel      (psel),
  .penable   (penable),
  .paddr     (paddr),
  .pwrite    (pwrite),
  .pwdata    (pwdata),
  .pready    (pready),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata)
);

// File: tb/apbm_requester_bench.sv
module apbm_requester_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_addr = '0;
  logic        cmd_write = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic [3:0]  psel;
  logic        penable;
  logic [15:0] paddr;
  logic        pwrite;
  logic [31:0] pwdata;
  logic        pready;
  logic [31:0] prdata;
  logic        pslverr;

  int          errors = 0;
  int          checks = 0;
  int          cfg_waits = 0;
  bit          cfg_serr = 1'b0;
  int          wcnt = 0;
  logic [31:0] cap_wdata = '0;

  always #4 clk = ~clk;

  apbm_requester u_apbm_requester (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite),
    .pwdata(pwdata), .pready(pready), .prdata(prdata), .pslverr(pslverr)
  );

  // Peripheral model: cfg_waits low cycles of pready per access phase.
  assign pready  = penable && (wcnt == cfg_waits);
  assign pslverr = pready && cfg_serr;
  assign prdata  = {paddr, paddr} ^ 32'hC3C3_5A5A;

  always @(posedge clk) begin
    if (!penable || pready) wcnt <= 0;
    else                    wcnt <= wcnt + 1;
    if (penable && pready && pwrite) cap_wdata <= pwdata;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [15:0] a);
    return {a, a} ^ 32'hC3C3_5A5A;
  endfunction

  // Offer one command, wait for acceptance, then for completion.
  task automatic run_xfer(input logic [15:0] a, input bit w, input logic [31:0] d,
                          input int wt, input bit se, output int lat,
                          output logic [3:0] sel_seen, output logic [31:0] rd,
                          output bit e, output bit got);
    cfg_waits = wt;
    cfg_serr  = se;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_write = w; cmd_wdata = d;
    for (int k = 0; k < 50 && !cmd_ready; k++) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1; sel_seen = '0; got = 1'b0; rd = '0; e = 1'b0;
    for (int k = 0; k < 60; k++) begin
      if (psel != '0 && sel_seen == '0) sel_seen = psel;
      if (rsp_done) begin
        got = 1'b1; rd = rsp_rdata; e = rsp_err;
        break;
      end
      @(negedge clk);
      lat++;
    end
  endtask

  typedef struct packed {
    logic [15:0] addr;
    logic        wr;
    logic [31:0] wdata;
    logic [2:0]  waits;
    logic        serr;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{16'h0010, 1'b0, 32'h0000_0000, 3'd0, 1'b0},
    '{16'h1234, 1'b1, 32'hDEAD_BEEF, 3'd0, 1'b0},
    '{16'h2F00, 1'b0, 32'h0000_0000, 3'd2, 1'b0},
    '{16'h3ABC, 1'b1, 32'h1357_9BDF, 3'd1, 1'b1},
    '{16'h0FFC, 1'b0, 32'h0000_0000, 3'd4, 1'b1},
    '{16'h2004, 1'b1, 32'hA5A5_0F0F, 3'd3, 1'b0},
    '{16'h1FFF, 1'b0, 32'h0000_0000, 3'd0, 1'b0},
    '{16'h3000, 1'b0, 32'h0000_0000, 3'd1, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int          lat;
    logic [3:0]  ss;
    logic [31:0] rd;
    bit          e, got;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(psel == 4'b0 && !penable && !rsp_done, "R1 reset outputs",
        {27'd0, psel, penable}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1 && psel == 4'b0, "R1 ready after release",
        {31'd0, cmd_ready}, 32'd1);

    // Table: R2 R3 R5 R6 R8 R11
    for (int i = 0; i < 8; i++) begin
      run_xfer(VECS[i].addr, VECS[i].wr, VECS[i].wdata, int'(VECS[i].waits),
               VECS[i].serr, lat, ss, rd, e, got);
      chk(got, "R6 completion seen", {31'd0, got}, 32'd1);
      chk(lat == int'(VECS[i].waits) + 3, "R5 latency", lat,
          int'(VECS[i].waits) + 3);
      chk(ss == 4'(1 << VECS[i].addr[15:12]), "R2 select decode", {28'd0, ss},
          32'(1 << VECS[i].addr[15:12]));
      chk(e == VECS[i].serr, "R6 error flag", {31'd0, e}, {31'd0, VECS[i].serr});
      chk(rd == (VECS[i].wr ? 32'd0 : model_rd(VECS[i].addr)), "R6 read data", rd,
          VECS[i].wr ? 32'd0 : model_rd(VECS[i].addr));
      if (VECS[i].wr)
        chk(cap_wdata == VECS[i].wdata, "R11 write data at peripheral", cap_wdata,
            VECS[i].wdata);
      chk(psel == 4'b0 && !penable, "R8 idle after completion", {27'd0, psel, penable},
          32'd0);
      @(negedge clk);
      chk(!rsp_done, "R6 single-cycle pulse", {31'd0, rsp_done}, 32'd0);
    end

    // R9: unmapped addresses
    run_xfer(16'h5000, 1'b0, 32'd0, 0, 1'b0, lat, ss, rd, e, got);
    chk(got && lat == 1, "R9 unmapped latency", lat, 32'd1);
    chk(ss == 4'b0 && e && rd == 32'd0, "R9 unmapped error", {27'd0, ss, e}, 32'd1);
    run_xfer(16'hF004, 1'b1, 32'h1111_2222, 0, 1'b0, lat, ss, rd, e, got);
    chk(got && lat == 1 && e && ss == 4'b0, "R9 unmapped write", lat, 32'd1);

    // R7 R10 R3: back-to-back, slave 1 then slave 2, no waits
    cfg_waits = 0; cfg_serr = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = 16'h1040; cmd_write = 1'b0;
    @(negedge clk);  // setup of A
    cmd_addr = 16'h2080; cmd_write = 1'b1; cmd_wdata = 32'hCAFE_F00D;
    chk(!cmd_ready && psel == 4'b0010 && !penable, "R10 no ready in setup",
        {27'd0, psel, cmd_ready}, 32'h4);
    @(negedge clk);  // completing access of A
    chk(cmd_ready && penable && pready, "R10 ready on completing access",
        {31'd0, cmd_ready}, 32'd1);
    @(negedge clk);  // setup of B, done of A
    cmd_valid = 1'b0;
    chk(psel == 4'b0100 && !penable, "R7 direct setup", {27'd0, psel, penable},
        32'h8);
    chk(rsp_done && rsp_rdata == model_rd(16'h1040), "R7 first completes", rsp_rdata,
        model_rd(16'h1040));
    chk(pwrite && pwdata == 32'hCAFE_F00D, "R11 direction and data", pwdata,
        32'hCAFE_F00D);
    @(negedge clk);
    @(negedge clk);
    chk(rsp_done && cap_wdata == 32'hCAFE_F00D, "R7 second completes", cap_wdata,
        32'hCAFE_F00D);

    // R10 R9: unmapped command pending while a transfer completes
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = 16'h3008; cmd_write = 1'b0;
    @(negedge clk);
    cmd_addr = 16'h7000;
    @(negedge clk);  // completing access
    chk(!cmd_ready, "R10 unmapped refused in access", {31'd0, cmd_ready}, 32'd0);
    @(negedge clk);  // idle: done of first, unmapped accepted at next edge
    chk(rsp_done && !rsp_err && psel == 4'b0 && cmd_ready, "R9 idle before unmapped",
        {27'd0, psel, rsp_err}, 32'd0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(rsp_done && rsp_err && rsp_rdata == 32'd0, "R9 unmapped after idle",
        {31'd0, rsp_err}, 32'd1);

    // R4: hold during waits
    cfg_waits = 3;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = 16'h1ABC; cmd_write = 1'b1; cmd_wdata = 32'h0BAD_CAFE;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_addr = 16'h0000; cmd_wdata = 32'd0; cmd_write = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(penable && !pready && paddr == 16'h1ABC && pwdata == 32'h0BAD_CAFE
        && psel == 4'b0010 && !cmd_ready, "R4 hold while waiting", {16'd0, paddr},
        32'h1ABC);

    // R1: reset in the middle of an access
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(psel == 4'b0 && !penable && !rsp_done, "R1 reset mid-transfer",
        {27'd0, psel, penable}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cfg_waits = 0;
    @(negedge clk);
    chk(cmd_ready && psel == 4'b0, "R1 idle after reset", {31'd0, cmd_ready}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule